// File: doc/BRIEF.md
# Virtual-8086 Software Interrupt Redirector

This unit handles a software interrupt instruction executed while the processor runs a virtual-8086 task. From the 8-bit vector, the virtual-mode-extension enable bit and the current flags, it decides between three outcomes. The interrupt is either redirected through the real-mode vector table at linear address 0, handed to the protected-mode delivery path, or rejected with a general-protection fault with error code zero. The protected-mode delivery itself lies outside the unit.

When the extension is enabled, the unit reads a 16-bit pointer from the task state segment. It subtracts a fixed bias to locate a per-vector redirection bitmap, then fetches the byte that holds the vector's bit. A clear bit redirects. The unit reads the target IP and CS from the vector table, then pushes a 16-bit frame of flags, CS and IP onto the virtual-mode stack. When the I/O privilege level is below 3, the pushed flags carry the virtual interrupt flag in the interrupt-flag position and an I/O privilege field of 3.

All memory traffic goes through one request/acknowledge port. The memory may stall any request for any number of cycles. The result is reported with a one-cycle done strobe and a one-hot outcome, together with the new CS, IP and 16-bit SP.

Top module: `v86_int_redirector`

## Requirements
- R1: With vme_en low, an accepted start produces done in the next cycle with outcome protected (bit 1) when flags_lo[13:12] is 3, and fault (bit 2) otherwise. No memory request is issued.
- R2: With vme_en high, the first read is a word at tss_base + 102. The second read is a byte at tss_base + ((word - 32) mod 2^16) + vector[7:3], and bit vector[2:0] of that byte is the vector's bitmap bit.
- R3: A bitmap bit of 1 ends the operation with outcome protected when IOPL is 3 and fault otherwise. Nothing is written, new_sp equals sp_in, and new_cs/new_ip equal cs_in/ip_in.
- R4: A bitmap bit of 0 reads the word at vector*4 as the new IP and the word at vector*4 + 2 as the new CS. It reports outcome redirected (bit 0) with those values on new_ip and new_cs.
- R5: The pushed flags word equals flags_lo when IOPL is 3. Otherwise it is flags_lo with bit 9 replaced by vif and bits 13:12 set to 3.
- R6: On redirection, three word writes go to ss_base + (sp_in-2), (sp_in-4) and (sp_in-6), each offset taken mod 2^16. They carry the flags word, then cs_in, then ip_in, and new_sp is sp_in - 6 mod 2^16.
- R7: done is high for exactly one cycle per operation, and only then is outcome non-zero and one-hot. mem_req is low while done is high.
- R8: A start raised while an operation is in progress is ignored. A start raised in the cycle done is high is accepted.
- R9: After reset, done, outcome and mem_req are low and the unit is idle.
- R10: A memory request keeps mem_req, mem_addr, mem_we, mem_wide and mem_wdata unchanged until mem_ack is seen. A word request has mem_wide high, a byte request has it low, and a byte read returns its data in mem_rdata[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin handling a software interrupt (accepted when idle) |
| vector | input | 8 | Interrupt vector from the instruction |
| vme_en | input | 1 | Virtual-mode extensions enabled |
| flags_lo | input | 16 | Low 16 bits of the flags register (IF at 9, IOPL at 13:12) |
| vif | input | 1 | Virtual interrupt flag |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Address of the next instruction |
| sp_in | input | 16 | Current 16-bit stack pointer |
| tss_base | input | ADDR_W | Linear base of the task state segment |
| ss_base | input | ADDR_W | Linear base of the stack segment |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_wide | output | 1 | Word (1) or byte (0) access |
| mem_addr | output | ADDR_W | Linear byte address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| done | output | 1 | One-cycle completion strobe |
| outcome | output | 3 | One-hot: bit 0 redirected, bit 1 protected path, bit 2 fault |
| new_cs | output | 16 | Resulting CS |
| new_ip | output | 16 | Resulting IP |
| new_sp | output | 16 | Resulting SP |

## Verification
The completion report of one operation and the acceptance of the next start can fall in the same cycle, because done is raised as the unit returns to idle. The bench launches each following operation at the negedge where it sees done, so the new start is sampled in the done cycle. It mixes in short gaps, extension-disabled operations that finish in one cycle, and stalls from a randomly acknowledging memory. Each result is judged against a model of the memory: the outcome, target, stack pointer and every read and write address and value. A stray start pulse in the middle of an operation must leave that operation's results unchanged.

// File: rtl/v86_redir_pkg.sv
package v86_redir_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PTR     = 3'd1,
        ST_BITMAP  = 3'd2,
        ST_TGT_IP  = 3'd3,
        ST_TGT_CS  = 3'd4,
        ST_PUSH_FL = 3'd5,
        ST_PUSH_CS = 3'd6,
        ST_PUSH_IP = 3'd7
    } redir_state_e;

    localparam int OUT_W     = 3;
    localparam int OUT_REDIR = 0;
    localparam int OUT_PROT  = 1;
    localparam int OUT_FAULT = 2;

    localparam int FL_IF      = 9;
    localparam int FL_IOPL_LO = 12;
    localparam int FL_IOPL_HI = 13;

endpackage

// File: rtl/v86_flag_image.sv
module v86_flag_image
    import v86_redir_pkg::*;
(
    input  logic [15:0] flags_lo,
    input  logic        vif,
    output logic [15:0] image,
    output logic        iopl_max
);
    always_comb begin
        iopl_max = &flags_lo[FL_IOPL_HI:FL_IOPL_LO];
        image    = flags_lo;
        if (!iopl_max) begin
            image[FL_IF]                  = vif;
            image[FL_IOPL_HI:FL_IOPL_LO]  = 2'b11;
        end
    end
endmodule

// File: rtl/v86_route_decide.sv
module v86_route_decide
    import v86_redir_pkg::*;
(
    input  logic             allow_redirect,
    input  logic             iopl_max,
    output logic [OUT_W-1:0] outcome
);
    always_comb begin
        outcome = '0;
        if (allow_redirect)
            outcome[OUT_REDIR] = 1'b1;
        else if (iopl_max)
            outcome[OUT_PROT] = 1'b1;
        else
            outcome[OUT_FAULT] = 1'b1;
    end
endmodule

// File: rtl/v86_addr_unit.sv
module v86_addr_unit #(
    parameter int ADDR_W      = 32,
    parameter int IRB_PTR_OFS = 102,
    parameter int IRB_BIAS    = 32
) (
    input  logic [ADDR_W-1:0] tss_live,
    input  logic [ADDR_W-1:0] tss_held,
    input  logic [ADDR_W-1:0] ss_held,
    input  logic [7:0]        vec,
    input  logic [15:0]       ptr_word,
    input  logic [15:0]       sp,
    output logic [ADDR_W-1:0] ptr_addr,
    output logic [ADDR_W-1:0] bitmap_addr,
    output logic [ADDR_W-1:0] ivt_ip_addr,
    output logic [ADDR_W-1:0] ivt_cs_addr,
    output logic [ADDR_W-1:0] push_addr,
    output logic [15:0]       sp_dec
);
    localparam int                PAD     = ADDR_W - 16;
    localparam logic [15:0]       BIAS16  = 16'(IRB_BIAS);
    localparam logic [ADDR_W-1:0] PTR_OFS = ADDR_W'(IRB_PTR_OFS);

    logic [15:0] irb_base;

    always_comb begin
        irb_base    = ptr_word - BIAS16;
        ptr_addr    = tss_live + PTR_OFS;
        bitmap_addr = tss_held + {{PAD{1'b0}}, irb_base}
                               + {{(ADDR_W-5){1'b0}}, vec[7:3]};
        ivt_ip_addr = {{(ADDR_W-10){1'b0}}, vec, 2'b00};
        ivt_cs_addr = {{(ADDR_W-10){1'b0}}, vec, 2'b10};
        sp_dec      = sp - 16'd2;
        push_addr   = ss_held + {{PAD{1'b0}}, sp_dec};
    end
endmodule

// File: rtl/v86_int_redirector.sv
module v86_int_redirector
    import v86_redir_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int IRB_PTR_OFS = 102,
    parameter int IRB_BIAS    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        vector,
    input  logic              vme_en,
    input  logic [15:0]       flags_lo,
    input  logic              vif,
    input  logic [15:0]       cs_in,
    input  logic [15:0]       ip_in,
    input  logic [15:0]       sp_in,
    input  logic [ADDR_W-1:0] tss_base,
    input  logic [ADDR_W-1:0] ss_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [15:0]       mem_rdata,
    output logic              done,
    output logic [OUT_W-1:0]  outcome,
    output logic [15:0]       new_cs,
    output logic [15:0]       new_ip,
    output logic [15:0]       new_sp
);
    typedef struct packed {
        redir_state_e      st;
        logic [7:0]        vec;
        logic              iopl_max;
        logic [15:0]       fl_img;
        logic [15:0]       cs;
        logic [15:0]       ip;
        logic [15:0]       sp;
        logic [ADDR_W-1:0] tss;
        logic [ADDR_W-1:0] ss;
        logic              req;
        logic              we;
        logic              wide;
        logic [ADDR_W-1:0] addr;
        logic [15:0]       wdata;
        logic              done;
        logic [OUT_W-1:0]  outcome;
        logic [15:0]       tcs;
        logic [15:0]       tip;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic              busy;
    logic [15:0]       img_now;
    logic              iopl_now;
    logic [OUT_W-1:0]  entry_out;
    logic [OUT_W-1:0]  bitmap_out;
    logic              bm_bit;
    logic [ADDR_W-1:0] ptr_addr, bitmap_addr, ivt_ip_addr, ivt_cs_addr, push_addr;
    logic [15:0]       sp_dec;

    assign busy   = (ctx_q.st != ST_IDLE);
    assign bm_bit = mem_rdata[ctx_q.vec[2:0]];

    v86_flag_image u_flag (
        .flags_lo (flags_lo),
        .vif      (vif),
        .image    (img_now),
        .iopl_max (iopl_now)
    );

    v86_route_decide u_dec_entry (
        .allow_redirect (1'b0),
        .iopl_max       (iopl_now),
        .outcome        (entry_out)
    );

    v86_route_decide u_dec_bitmap (
        .allow_redirect (~bm_bit),
        .iopl_max       (ctx_q.iopl_max),
        .outcome        (bitmap_out)
    );

    v86_addr_unit #(
        .ADDR_W      (ADDR_W),
        .IRB_PTR_OFS (IRB_PTR_OFS),
        .IRB_BIAS    (IRB_BIAS)
    ) u_addr (
        .tss_live    (tss_base),
        .tss_held    (ctx_q.tss),
        .ss_held     (ctx_q.ss),
        .vec         (ctx_q.vec),
        .ptr_word    (mem_rdata),
        .sp          (ctx_q.sp),
        .ptr_addr    (ptr_addr),
        .bitmap_addr (bitmap_addr),
        .ivt_ip_addr (ivt_ip_addr),
        .ivt_cs_addr (ivt_cs_addr),
        .push_addr   (push_addr),
        .sp_dec      (sp_dec)
    );

    always_comb begin
        ctx_d         = ctx_q;
        ctx_d.done    = 1'b0;
        ctx_d.outcome = '0;
        case (ctx_q.st)
            ST_IDLE: begin
                if (start && !busy) begin
                    ctx_d.vec      = vector;
                    ctx_d.iopl_max = iopl_now;
                    ctx_d.fl_img   = img_now;
                    ctx_d.cs       = cs_in;
                    ctx_d.ip       = ip_in;
                    ctx_d.sp       = sp_in;
                    ctx_d.tss      = tss_base;
                    ctx_d.ss       = ss_base;
                    ctx_d.tcs      = cs_in;
                    ctx_d.tip      = ip_in;
                    if (!vme_en) begin
                        ctx_d.done    = 1'b1;
                        ctx_d.outcome = entry_out;
                    end else begin
                        ctx_d.st   = ST_PTR;
                        ctx_d.req  = 1'b1;
                        ctx_d.we   = 1'b0;
                        ctx_d.wide = 1'b1;
                        ctx_d.addr = ptr_addr;
                    end
                end
            end
            ST_PTR: begin
                if (mem_ack) begin
                    ctx_d.st   = ST_BITMAP;
                    ctx_d.wide = 1'b0;
                    ctx_d.addr = bitmap_addr;
                end
            end
            ST_BITMAP: begin
                if (mem_ack) begin
                    if (bitmap_out[OUT_REDIR]) begin
                        ctx_d.st   = ST_TGT_IP;
                        ctx_d.wide = 1'b1;
                        ctx_d.addr = ivt_ip_addr;
                    end else begin
                        ctx_d.st      = ST_IDLE;
                        ctx_d.req     = 1'b0;
                        ctx_d.wide    = 1'b0;
                        ctx_d.done    = 1'b1;
                        ctx_d.outcome = bitmap_out;
                    end
                end
            end
            ST_TGT_IP: begin
                if (mem_ack) begin
                    ctx_d.tip  = mem_rdata;
                    ctx_d.st   = ST_TGT_CS;
                    ctx_d.addr = ivt_cs_addr;
                end
            end
            ST_TGT_CS: begin
                if (mem_ack) begin
                    ctx_d.tcs   = mem_rdata;
                    ctx_d.st    = ST_PUSH_FL;
                    ctx_d.we    = 1'b1;
                    ctx_d.addr  = push_addr;
                    ctx_d.wdata = ctx_q.fl_img;
                    ctx_d.sp    = sp_dec;
                end
            end
            ST_PUSH_FL: begin
                if (mem_ack) begin
                    ctx_d.st    = ST_PUSH_CS;
                    ctx_d.addr  = push_addr;
                    ctx_d.wdata = ctx_q.cs;
                    ctx_d.sp    = sp_dec;
                end
            end
            ST_PUSH_CS: begin
                if (mem_ack) begin
                    ctx_d.st    = ST_PUSH_IP;
                    ctx_d.addr  = push_addr;
                    ctx_d.wdata = ctx_q.ip;
                    ctx_d.sp    = sp_dec;
                end
            end
            ST_PUSH_IP: begin
                if (mem_ack) begin
                    ctx_d.st                 = ST_IDLE;
                    ctx_d.req                = 1'b0;
                    ctx_d.we                 = 1'b0;
                    ctx_d.done               = 1'b1;
                    ctx_d.outcome[OUT_REDIR] = 1'b1;
                end
            end
            default: begin
                ctx_d.st  = ST_IDLE;
                ctx_d.req = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign mem_req   = ctx_q.req;
    assign mem_we    = ctx_q.we;
    assign mem_wide  = ctx_q.wide;
    assign mem_addr  = ctx_q.addr;
    assign mem_wdata = ctx_q.wdata;
    assign done      = ctx_q.done;
    assign outcome   = ctx_q.outcome;
    assign new_cs    = ctx_q.tcs;
    assign new_ip    = ctx_q.tip;
    assign new_sp    = ctx_q.sp;

endmodule

// File: rtl/v86_redir_chk.sv
module v86_redir_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              vme_en,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_wide,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [15:0]       mem_wdata,
    input logic              mem_ack,
    input logic              done,
    input logic [2:0]        outcome
);
    AST_OUT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones(outcome) == 1)); // R7

    AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (outcome == 3'b000)); // R7

    AST_BUS_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req); // R7

    AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done); // R8

    AST_VME_OFF_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !vme_en) |=> (done && !outcome[0] && !mem_req)); // R1

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wide) && $stable(mem_wdata))); // R10

    AST_WRITE_IS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wide); // R6

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!done && !mem_req)); // R9
endmodule

bind v86_int_redirector v86_redir_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .vme_en    (vme_en),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_wide  (mem_wide),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .done      (done),
    .outcome   (outcome)
);

// File: tb/sim_v86_int_redirector.sv
`timescale 1ns/1ps
module sim_v86_int_redirector;
    localparam int ADDR_W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  vector = '0;
    logic        vme_en = 1'b0;
    logic [15:0] flags_lo = '0;
    logic        vif = 1'b0;
    logic [15:0] cs_in = '0, ip_in = '0, sp_in = '0;
    logic [31:0] tss_base = '0, ss_base = '0;
    logic        mem_req, mem_we, mem_wide;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        done;
    logic [2:0]  outcome;
    logic [15:0] new_cs, new_ip, new_sp;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    logic [7:0]  mem_b [int unsigned];
    logic [31:0] wr_addr_q [$];
    logic [15:0] wr_data_q [$];
    logic [31:0] rd_addr_q [$];

    always #4 clk = ~clk;

    v86_int_redirector #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .vector(vector), .vme_en(vme_en),
        .flags_lo(flags_lo), .vif(vif), .cs_in(cs_in), .ip_in(ip_in), .sp_in(sp_in),
        .tss_base(tss_base), .ss_base(ss_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .outcome(outcome), .new_cs(new_cs), .new_ip(new_ip), .new_sp(new_sp)
    );

    function automatic logic [7:0] rd_b(input logic [31:0] a);
        if (mem_b.exists(a)) return mem_b[a];
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [15:0] exp_img(input logic [15:0] f, input logic vi);
        logic [15:0] r;
        r = f;
        if (f[13:12] != 2'b11) begin
            r[9]     = vi;
            r[13:12] = 2'b11;
        end
        return r;
    endfunction

    function automatic logic [2:0] exp_out(input logic vme, input logic bm, input logic [15:0] f);
        if (vme && !bm) return 3'b001;
        return (f[13:12] == 2'b11) ? 3'b010 : 3'b100;
    endfunction

    task automatic wr_w(input logic [31:0] a, input logic [15:0] d);
        mem_b[a]      = d[7:0];
        mem_b[a + 1]  = d[15:8];
    endtask

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory responder: random stalls, model updates at grant
    always @(negedge clk) begin
        cycles++;
        if (rst_n && mem_req && ($urandom_range(0, 9) < 7)) begin
            mem_ack = 1'b1;
            if (mem_we) begin
                wr_addr_q.push_back(mem_addr);
                wr_data_q.push_back(mem_wdata);
                wr_w(mem_addr, mem_wdata);
            end else begin
                rd_addr_q.push_back(mem_addr);
                mem_rdata = mem_wide ? {rd_b(mem_addr + 1), rd_b(mem_addr)} : {8'h00, rd_b(mem_addr)};
            end
        end else begin
            mem_ack = 1'b0;
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            n_errors++;
            $display("FAIL R7 watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic do_op(input logic [7:0] v, input logic vme, input logic [15:0] fl, input logic vi,
                         input logic [15:0] cs, input logic [15:0] ip, input logic [15:0] sp,
                         input logic [31:0] tss, input logic [31:0] ss, input logic [15:0] irb_raw,
                         input logic bm, input logic [15:0] t_ip, input logic [15:0] t_cs,
                         input bit poke, input bit chained);
        logic [31:0] ba;
        logic [7:0]  b;
        logic [2:0]  eo;
        int          w;
        ba = tss + {16'h0, irb_raw - 16'd32} + {27'h0, v[7:3]};
        b  = 8'($urandom);
        b[v[2:0]] = bm;
        wr_w(tss + 32'd102, irb_raw);
        mem_b[ba] = b;
        wr_w({22'h0, v, 2'b00}, t_ip);
        wr_w({22'h0, v, 2'b10}, t_cs);
        eo = exp_out(vme, bm, fl);
        wr_addr_q.delete(); wr_data_q.delete(); rd_addr_q.delete();
        vector = v; vme_en = vme; flags_lo = fl; vif = vi; cs_in = cs; ip_in = ip;
        sp_in = sp; tss_base = tss; ss_base = ss;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke && vme) begin
            // R8: stray start while busy with other inputs
            vector = ~v; vme_en = 1'b0; flags_lo = ~fl; sp_in = ~sp; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (!done && w < 400) begin
            @(negedge clk);
            w++;
        end
        chk(done == 1'b1, chained ? "R8 start in done cycle completes" : "R7 done seen", 32'(done), 32'd1);
        chk(outcome == eo, !vme ? "R1 outcome" : (bm ? "R3 outcome" : "R4 outcome"), 32'(outcome), 32'(eo));
        if (!vme) begin
            chk(rd_addr_q.size() == 0 && wr_addr_q.size() == 0, "R1 no memory access",
                32'(rd_addr_q.size() + wr_addr_q.size()), 32'd0);
        end else begin
            chk(rd_addr_q.size() >= 2, "R2 read count", 32'(rd_addr_q.size()), 32'd2);
            if (rd_addr_q.size() >= 2) begin
                chk(rd_addr_q[0] == tss + 32'd102, "R2 pointer address", rd_addr_q[0], tss + 32'd102);
                chk(rd_addr_q[1] == ba, "R2 bitmap byte address", rd_addr_q[1], ba);
            end
        end
        if (eo == 3'b001) begin
            chk(new_ip == t_ip, "R4 new_ip", 32'(new_ip), 32'(t_ip));
            chk(new_cs == t_cs, "R4 new_cs", 32'(new_cs), 32'(t_cs));
            if (rd_addr_q.size() == 4) begin
                chk(rd_addr_q[2] == {22'h0, v, 2'b00}, "R4 ip address", rd_addr_q[2], {22'h0, v, 2'b00});
                chk(rd_addr_q[3] == {22'h0, v, 2'b10}, "R4 cs address", rd_addr_q[3], {22'h0, v, 2'b10});
            end else begin
                chk(1'b0, "R4 read count", 32'(rd_addr_q.size()), 32'd4);
            end
            chk(new_sp == 16'(sp - 16'd6), "R6 new_sp", 32'(new_sp), 32'(16'(sp - 16'd6)));
            chk(wr_addr_q.size() == 3, "R6 write count", 32'(wr_addr_q.size()), 32'd3);
            if (wr_addr_q.size() == 3) begin
                chk(wr_data_q[0] == exp_img(fl, vi), "R5 pushed flags", 32'(wr_data_q[0]), 32'(exp_img(fl, vi)));
                chk(wr_data_q[1] == cs, "R6 pushed cs", 32'(wr_data_q[1]), 32'(cs));
                chk(wr_data_q[2] == ip, "R6 pushed ip", 32'(wr_data_q[2]), 32'(ip));
                for (int k = 0; k < 3; k++) begin
                    logic [31:0] ea;
                    ea = ss + {16'h0, 16'(sp - 16'(2 * (k + 1)))};
                    chk(wr_addr_q[k] == ea, "R6 push address", wr_addr_q[k], ea);
                end
            end
        end else begin
            chk(new_sp == sp, "R3 new_sp unchanged", 32'(new_sp), 32'(sp));
            chk(new_cs == cs && new_ip == ip, "R3 cs/ip unchanged", {new_cs, new_ip}, {cs, ip});
            chk(wr_addr_q.size() == 0, "R3 no pushes", 32'(wr_addr_q.size()), 32'd0);
        end
    endtask

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && outcome == 3'b000 && mem_req == 1'b0, "R9 reset state",
            {29'h0, done, mem_req, |outcome}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && mem_req == 1'b0, "R9 idle after reset", {30'h0, done, mem_req}, 32'd0);

        // R1 extension disabled
        do_op(8'h21, 1'b0, 16'h3202, 1'b0, 16'h1000, 16'h0100, 16'hFFF0, 32'h0010_0000, 32'h4000_0000, 16'h0088, 1'b0, 16'h1111, 16'h2222, 0, 0);
        do_op(8'h21, 1'b0, 16'h1202, 1'b0, 16'h1000, 16'h0100, 16'hFFF0, 32'h0010_0000, 32'h4000_0000, 16'h0088, 1'b0, 16'h1111, 16'h2222, 0, 1);
        // R3 bitmap bit set
        do_op(8'h13, 1'b1, 16'h3002, 1'b1, 16'h2000, 16'h0200, 16'h8000, 32'h0012_3400, 32'h4000_1000, 16'h0090, 1'b1, 16'h3333, 16'h4444, 0, 1);
        do_op(8'h13, 1'b1, 16'h2002, 1'b1, 16'h2000, 16'h0200, 16'h8000, 32'h0012_3400, 32'h4000_1000, 16'h0090, 1'b1, 16'h3333, 16'h4444, 0, 1);
        // R5 flag image variants
        do_op(8'h10, 1'b1, 16'h0002, 1'b1, 16'h3000, 16'h0300, 16'h7000, 32'h0013_0000, 32'h4000_2000, 16'h0068, 1'b0, 16'h5555, 16'h6666, 0, 1);
        do_op(8'h10, 1'b1, 16'h1202, 1'b0, 16'h3000, 16'h0300, 16'h7000, 32'h0013_0000, 32'h4000_2000, 16'h0068, 1'b0, 16'h5555, 16'h6666, 0, 1);
        do_op(8'h10, 1'b1, 16'h3002, 1'b1, 16'h3000, 16'h0300, 16'h7000, 32'h0013_0000, 32'h4000_2000, 16'h0068, 1'b0, 16'h5555, 16'h6666, 0, 1);
        // R2 / R4 / R6 corners: vector extremes, pointer wrap, stack wrap
        do_op(8'hFF, 1'b1, 16'h0202, 1'b0, 16'hABCD, 16'h1234, 16'h0002, 32'h0014_0000, 32'h4000_3000, 16'h0010, 1'b0, 16'h7777, 16'h8888, 0, 1);
        do_op(8'h00, 1'b1, 16'h0202, 1'b1, 16'hABCD, 16'h1234, 16'h0000, 32'h0015_0000, 32'h4000_4000, 16'hFFFF, 1'b0, 16'h9999, 16'hAAAA, 0, 1);
        // R8 stray start during an operation
        do_op(8'h42, 1'b1, 16'h1002, 1'b1, 16'h0C00, 16'h0042, 16'h5000, 32'h0016_0000, 32'h4000_5000, 16'h0100, 1'b0, 16'hBBBB, 16'hCCCC, 1, 1);

        for (int i = 0; i < 300; i++) begin
            logic vme_r;
            vme_r = ($urandom_range(0, 4) != 0);
            if ($urandom_range(0, 2) == 0) repeat ($urandom_range(1, 3)) @(negedge clk);
            do_op(8'($urandom), vme_r, 16'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
                  16'($urandom), 32'h0010_0000 + {12'h0, 20'($urandom) & 20'hF_FFF0},
                  32'h4000_0000 + {4'h0, 28'($urandom) & 28'h0FF_FFF0}, 16'($urandom),
                  1'($urandom), 16'($urandom), 16'($urandom), ($urandom_range(0, 7) == 0), 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule